// File: doc/BRIEF.md
# Three-Pointer Store Queue

This block holds the in-flight stores of one thread in an out-of-order core. Each store gets a slot at dispatch and is tagged with its sequence number. The execute stage later writes the store's address, byte size and up to eight data bytes into that slot. The commit stage announces a sequence number, and every older store becomes committed and eligible for memory.

The slots form a ring with three indices. The head is the oldest store not yet finished in memory. The writeback index is the next committed store to hand to memory. The tail is the next free slot. Because of the middle index, a store can be committed and sent while it still occupies its slot. A slot is freed only when memory reports completion.

A squash trims speculative stores from the tail end. Memory may refuse a write; the block then holds the same store until a retry pulse arrives.

Top module: `store_queue_wb`

## Requirements
- R1: A synchronous active-high reset empties the queue: count 0, all three indices 0, pending-writeback count 0, not blocked, no memory request.
- R2: An accepted allocation stores the sequence number at the tail slot, advances `alloc_idx` by one and raises the count by one.
- R3: The queue keeps one slot unused and reports full when the count reaches SLOTS-1. While full, `alloc_ready` is low and an allocation request changes neither count nor `alloc_idx`.
- R4: An execute write places the address, size and data into the named slot. A committed store is never offered to memory before its execute write.
- R5: A commit with sequence number C marks as committed, and eligible for writeback, every queued uncommitted store whose tag is strictly less than C. Other stores are unaffected.
- R6: `wb_pending` counts committed stores not yet accepted by memory, and `wb_any` is high exactly when it is non-zero.
- R7: Stores reach memory in queue order from the writeback index. A request is shown when that store is committed, executed, not completed and the block is not blocked. Address, size and data are those of the execute write, and the index advances on accept.
- R8: Commit and memory accept never free a slot. Each `mem_done` pulse frees the head slot only if it was already sent. A `mem_done` with no sent store is ignored.
- R9: A request seen with `mem_accept` low sets `store_blocked` on the next cycle and withdraws the request. The same store is offered again after a `mem_retry` pulse clears the block.
- R10: A squash with sequence number S removes every uncommitted store whose tag exceeds S by pulling the tail back. It never removes a committed store, and allocation is ignored in that cycle.
- R11: All three indices wrap modulo SLOTS, so storage beyond the last slot continues at slot 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| alloc_valid | input | 1 | Allocate a slot for a new store |
| alloc_seq | input | SEQ_W | Sequence number of the new store |
| alloc_ready | output | 1 | Queue can take an allocation |
| alloc_idx | output | log2(SLOTS) | Slot the next allocation uses |
| exec_valid | input | 1 | Write execute results into a slot |
| exec_idx | input | log2(SLOTS) | Slot being written |
| exec_addr | input | ADDR_W | Effective address |
| exec_size | input | SIZE_W | Store size in bytes (1..8) |
| exec_data | input | DATA_W | Store data |
| commit_valid | input | 1 | Commit stores older than commit_seq |
| commit_seq | input | SEQ_W | Commit boundary |
| squash_valid | input | 1 | Remove stores younger than squash_seq |
| squash_seq | input | SEQ_W | Youngest surviving sequence number |
| mem_req_valid | output | 1 | Write request to memory |
| mem_req_addr | output | ADDR_W | Request address |
| mem_req_size | output | SIZE_W | Request size |
| mem_req_data | output | DATA_W | Request data |
| mem_accept | input | 1 | Memory takes the request this cycle |
| mem_retry | input | 1 | Memory can accept again |
| mem_done | input | 1 | Oldest sent write has completed |
| store_blocked | output | 1 | A refused request is waiting for retry |
| sq_count | output | log2(SLOTS+1) | Occupied slots |
| sq_full | output | 1 | Count has reached SLOTS-1 |
| wb_pending | output | log2(SLOTS+1) | Committed stores not yet accepted |
| wb_any | output | 1 | wb_pending is non-zero |

## Verification
Commit is tried with three patterns. First, a boundary above every queued tag, with no execute data yet; this separates "committed" from "offered to memory". Second, a boundary that cuts the queue in the middle, which shows that the younger store stays unsent. Third, a boundary after a squash, which shows that only survivors drain.

Draining runs with memory accepting every cycle, with memory refusing and then retrying, and with the queue full across the wrap point. A scoreboard compares each accepted request against the stores in commit order. Two squashes are applied: one that removes only uncommitted stores, and one whose boundary lies below a committed store that must survive.

// File: rtl/sq_pkg.sv
package sq_pkg;

  // Successor of a ring index.
  function automatic int ring_next(input int p, input int depth);
    return (p == depth - 1) ? 0 : p + 1;
  endfunction

  // Distance walking forward from one ring index to another.
  function automatic int ring_dist(input int from_p, input int to_p, input int depth);
    return (to_p >= from_p) ? to_p - from_p : to_p + depth - from_p;
  endfunction

  // Ring index k steps ahead of p.
  function automatic int ring_add(input int p, input int k, input int depth);
    return (p + k) % depth;
  endfunction

endpackage

// File: rtl/sq_payload_ram.sv
module sq_payload_ram #(
  parameter int DEPTH = 8,
  parameter int WIDTH = 100,
  parameter int IW    = $clog2(DEPTH)
) (
  input  logic             clk,
  input  logic             we,
  input  logic [IW-1:0]    waddr,
  input  logic [WIDTH-1:0] wdata,
  input  logic [IW-1:0]    raddr,
  output logic [WIDTH-1:0] rdata
);
  logic [WIDTH-1:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (we) mem[waddr] <= wdata;
  end

  assign rdata = mem[raddr];
endmodule

// File: rtl/sq_age_scan.sv
module sq_age_scan #(
  parameter int SLOTS = 8,
  parameter int SEQ_W = 16,
  parameter int IW    = $clog2(SLOTS),
  parameter int CW    = $clog2(SLOTS + 1)
) (
  input  logic [IW-1:0]                 head,
  input  logic [IW-1:0]                 wb,
  input  logic [IW-1:0]                 tail,
  input  logic [SLOTS-1:0][SEQ_W-1:0]   seq_tags,
  input  logic [SLOTS-1:0]              committed,
  input  logic [SEQ_W-1:0]              commit_seq,
  input  logic [SEQ_W-1:0]              squash_seq,
  output logic [SLOTS-1:0]              commit_mask,
  output logic [CW-1:0]                 keep_cnt
);
  import sq_pkg::*;

  always_comb begin
    int occ;
    int span;
    occ  = ring_dist(int'(head), int'(tail), SLOTS);
    span = ring_dist(int'(wb), int'(tail), SLOTS);
    commit_mask = '0;
    keep_cnt    = '0;
    // Commit: every live, uncommitted slot older than the boundary.
    for (int i = 0; i < SLOTS; i++) begin
      if (ring_dist(int'(head), i, SLOTS) < occ && !committed[i] &&
          seq_tags[i] < commit_seq)
        commit_mask[i] = 1'b1;
    end
    // Squash: survivors form a prefix starting at the writeback index.
    for (int k = 0; k < SLOTS; k++) begin
      int idx;
      idx = ring_add(int'(wb), k, SLOTS);
      if (k < span && (committed[idx] || seq_tags[idx] <= squash_seq))
        keep_cnt = keep_cnt + CW'(1);
    end
  end
endmodule

// File: rtl/store_queue_wb.sv
module store_queue_wb #(
  parameter int SLOTS  = 8,
  parameter int SEQ_W  = 16,
  parameter int ADDR_W = 32,
  parameter int DATA_W = 64,
  parameter int SIZE_W = 4
) (
  input  logic                       clk,
  input  logic                       rst,
  input  logic                       alloc_valid,
  input  logic [SEQ_W-1:0]           alloc_seq,
  output logic                       alloc_ready,
  output logic [$clog2(SLOTS)-1:0]   alloc_idx,
  input  logic                       exec_valid,
  input  logic [$clog2(SLOTS)-1:0]   exec_idx,
  input  logic [ADDR_W-1:0]          exec_addr,
  input  logic [SIZE_W-1:0]          exec_size,
  input  logic [DATA_W-1:0]          exec_data,
  input  logic                       commit_valid,
  input  logic [SEQ_W-1:0]           commit_seq,
  input  logic                       squash_valid,
  input  logic [SEQ_W-1:0]           squash_seq,
  output logic                       mem_req_valid,
  output logic [ADDR_W-1:0]          mem_req_addr,
  output logic [SIZE_W-1:0]          mem_req_size,
  output logic [DATA_W-1:0]          mem_req_data,
  input  logic                       mem_accept,
  input  logic                       mem_retry,
  input  logic                       mem_done,
  output logic                       store_blocked,
  output logic [$clog2(SLOTS+1)-1:0] sq_count,
  output logic                       sq_full,
  output logic [$clog2(SLOTS+1)-1:0] wb_pending,
  output logic                       wb_any
);
  import sq_pkg::*;

  localparam int IW = $clog2(SLOTS);
  localparam int CW = $clog2(SLOTS + 1);
  localparam int PW = ADDR_W + SIZE_W + DATA_W;

  logic [IW-1:0]             head_q, wb_q, tail_q;
  logic [CW-1:0]             wb_cnt_q, occ, keep_cnt;
  logic                      blocked_q;
  logic [SLOTS-1:0][SEQ_W-1:0] seq_q;
  logic [SLOTS-1:0]          has_data_q, committed_q, can_wb_q, completed_q;
  logic [SLOTS-1:0]          commit_mask;
  logic [PW-1:0]             rd_word;
  logic                      do_alloc, do_issue, do_done, do_commit, wb_ready;

  assign occ       = CW'(ring_dist(int'(head_q), int'(tail_q), SLOTS));
  assign sq_full   = occ >= CW'(SLOTS - 1);
  assign do_alloc  = alloc_valid && !sq_full && !squash_valid;
  assign do_commit = commit_valid && !squash_valid;
  assign do_issue  = mem_req_valid && mem_accept;
  assign do_done   = mem_done && (head_q != wb_q);
  assign wb_ready  = (wb_q != tail_q) && can_wb_q[wb_q] && has_data_q[wb_q] &&
                     !completed_q[wb_q] && !blocked_q;

  sq_age_scan #(.SLOTS(SLOTS), .SEQ_W(SEQ_W), .IW(IW), .CW(CW)) i_scan (
    .head(head_q), .wb(wb_q), .tail(tail_q), .seq_tags(seq_q),
    .committed(committed_q), .commit_seq(commit_seq), .squash_seq(squash_seq),
    .commit_mask(commit_mask), .keep_cnt(keep_cnt)
  );

  sq_payload_ram #(.DEPTH(SLOTS), .WIDTH(PW), .IW(IW)) i_ram (
    .clk(clk), .we(exec_valid), .waddr(exec_idx),
    .wdata({exec_addr, exec_size, exec_data}),
    .raddr(wb_q), .rdata(rd_word)
  );

  // Per-slot tag and state flags.
  for (genvar g = 0; g < SLOTS; g++) begin : g_slot
    logic [SEQ_W-1:0] tag_r;
    logic hd_r, cm_r, cw_r, cp_r;
    logic hit_alloc, hit_exec, hit_done;
    assign hit_alloc = do_alloc && (tail_q == IW'(g));
    assign hit_exec  = exec_valid && (exec_idx == IW'(g));
    assign hit_done  = do_done && (head_q == IW'(g));
    always_ff @(posedge clk) begin
      if (rst) begin
        tag_r <= '0; hd_r <= 1'b0; cm_r <= 1'b0; cw_r <= 1'b0; cp_r <= 1'b0;
      end else if (hit_alloc) begin
        tag_r <= alloc_seq; hd_r <= 1'b0; cm_r <= 1'b0; cw_r <= 1'b0; cp_r <= 1'b0;
      end else begin
        if (hit_exec) hd_r <= 1'b1;
        if (do_commit && commit_mask[g]) begin
          cm_r <= 1'b1;
          cw_r <= 1'b1;
        end
        if (hit_done) cp_r <= 1'b1;
      end
    end
    assign seq_q[g]       = tag_r;
    assign has_data_q[g]  = hd_r;
    assign committed_q[g] = cm_r;
    assign can_wb_q[g]    = cw_r;
    assign completed_q[g] = cp_r;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      head_q    <= '0;
      wb_q      <= '0;
      tail_q    <= '0;
      wb_cnt_q  <= '0;
      blocked_q <= 1'b0;
    end else begin
      if (do_done)  head_q <= IW'(ring_next(int'(head_q), SLOTS));
      if (do_issue) wb_q   <= IW'(ring_next(int'(wb_q), SLOTS));
      if (squash_valid)
        tail_q <= IW'(ring_add(int'(wb_q), int'(keep_cnt), SLOTS));
      else if (do_alloc)
        tail_q <= IW'(ring_next(int'(tail_q), SLOTS));
      wb_cnt_q <= wb_cnt_q + CW'($countones(commit_mask & {SLOTS{do_commit}}))
                  - CW'(do_issue);
      if (mem_retry)
        blocked_q <= 1'b0;
      else if (mem_req_valid && !mem_accept)
        blocked_q <= 1'b1;
    end
  end

  assign alloc_ready   = !sq_full;
  assign alloc_idx     = tail_q;
  assign mem_req_valid = wb_ready;
  assign {mem_req_addr, mem_req_size, mem_req_data} = rd_word;
  assign store_blocked = blocked_q;
  assign sq_count      = occ;
  assign wb_pending    = wb_cnt_q;
  assign wb_any        = wb_cnt_q != '0;

  assert_occ_bound_R3: assert property (@(posedge clk) disable iff (rst)
    occ <= CW'(SLOTS - 1));

  assert_full_no_alloc_R3: assert property (@(posedge clk) disable iff (rst)
    (alloc_valid && sq_full && !squash_valid) |=> $stable(tail_q));

  assert_pending_bound_R6: assert property (@(posedge clk) disable iff (rst)
    wb_cnt_q <= CW'(ring_dist(int'(wb_q), int'(tail_q), SLOTS)));

  assert_wb_inside_R7: assert property (@(posedge clk) disable iff (rst)
    ring_dist(int'(head_q), int'(wb_q), SLOTS) <= int'(occ));

  assert_head_hold_R8: assert property (@(posedge clk) disable iff (rst)
    !mem_done |=> $stable(head_q));

  assert_refuse_block_R9: assert property (@(posedge clk) disable iff (rst)
    (mem_req_valid && !mem_accept && !mem_retry) |=>
      (store_blocked && !mem_req_valid && $stable(wb_q)));
endmodule

// File: tb/test_store_queue_wb.sv
module test_store_queue_wb;
  localparam int SLOTS = 8;
  localparam int SEQ_W = 16;
  localparam int IW = $clog2(SLOTS);
  localparam int CW = $clog2(SLOTS + 1);

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic alloc_valid = 1'b0, exec_valid = 1'b0, commit_valid = 1'b0, squash_valid = 1'b0;
  logic [SEQ_W-1:0] alloc_seq = '0, commit_seq = '0, squash_seq = '0;
  logic [IW-1:0] exec_idx = '0;
  logic [31:0] exec_addr = '0;
  logic [3:0]  exec_size = '0;
  logic [63:0] exec_data = '0;
  logic mem_accept = 1'b0, mem_retry = 1'b0, mem_done = 1'b0;
  logic alloc_ready, mem_req_valid, store_blocked, sq_full, wb_any;
  logic [IW-1:0] alloc_idx;
  logic [31:0] mem_req_addr;
  logic [3:0]  mem_req_size;
  logic [63:0] mem_req_data;
  logic [CW-1:0] sq_count, wb_pending;

  int n_chk = 0;
  int n_fail = 0;

  typedef struct { logic [31:0] addr; logic [3:0] size; logic [63:0] data; } exp_t;
  exp_t exp_q[$];

  always #10 clk = ~clk;

  store_queue_wb #(.SLOTS(SLOTS), .SEQ_W(SEQ_W)) i_store_queue_wb (
    .clk(clk), .rst(rst),
    .alloc_valid(alloc_valid), .alloc_seq(alloc_seq), .alloc_ready(alloc_ready),
    .alloc_idx(alloc_idx),
    .exec_valid(exec_valid), .exec_idx(exec_idx), .exec_addr(exec_addr),
    .exec_size(exec_size), .exec_data(exec_data),
    .commit_valid(commit_valid), .commit_seq(commit_seq),
    .squash_valid(squash_valid), .squash_seq(squash_seq),
    .mem_req_valid(mem_req_valid), .mem_req_addr(mem_req_addr),
    .mem_req_size(mem_req_size), .mem_req_data(mem_req_data),
    .mem_accept(mem_accept), .mem_retry(mem_retry), .mem_done(mem_done),
    .store_blocked(store_blocked), .sq_count(sq_count), .sq_full(sq_full),
    .wb_pending(wb_pending), .wb_any(wb_any)
  );

  function automatic logic [31:0] a_of(int s); return 32'h1000 + 32'(s) * 8; endfunction
  function automatic logic [63:0] d_of(int s); return {32'hC0DE0000 + 32'(s), ~32'(s)}; endfunction
  function automatic logic [3:0]  z_of(int s); return 4'((s % 8) + 1); endfunction

  task automatic tick(); @(posedge clk); #2; endtask

  task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: got %0h expected %0h", tag, act, exp);
    end
  endtask

  task automatic want(int s);
    exp_t e;
    e.addr = a_of(s); e.size = z_of(s); e.data = d_of(s);
    exp_q.push_back(e);
  endtask

  task automatic alloc(int s);
    alloc_valid = 1'b1; alloc_seq = SEQ_W'(s); tick(); alloc_valid = 1'b0;
  endtask

  task automatic exec_st(int idx, int s);
    exec_valid = 1'b1; exec_idx = IW'(idx);
    exec_addr = a_of(s); exec_size = z_of(s); exec_data = d_of(s);
    tick(); exec_valid = 1'b0;
  endtask

  task automatic commit(int s);
    commit_valid = 1'b1; commit_seq = SEQ_W'(s); tick(); commit_valid = 1'b0;
  endtask

  task automatic squash(int s);
    squash_valid = 1'b1; squash_seq = SEQ_W'(s); tick(); squash_valid = 1'b0;
  endtask

  task automatic done_n(int n);
    mem_done = 1'b1; repeat (n) tick(); mem_done = 1'b0;
  endtask

  task automatic finish_run();
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  endtask

  // Scoreboard monitor: each accepted write is compared with the next expected one.
  always @(negedge clk) begin
    if (!rst && mem_req_valid && mem_accept) begin
      if (exp_q.size() == 0) begin
        n_chk++; n_fail++;
        $display("FAIL R7 unexpected write: got %0h expected none", mem_req_addr);
      end else begin
        exp_t e;
        e = exp_q.pop_front();
        chk("R7 write address", 64'(mem_req_addr), 64'(e.addr));
        chk("R4 write size", 64'(mem_req_size), 64'(e.size));
        chk("R4 write data", mem_req_data, e.data);
      end
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    n_chk++; n_fail++;
    $display("FAIL watchdog: got timeout expected completion");
    finish_run();
  end

  initial begin
    repeat (3) tick();
    rst = 1'b0;
    // R1 reset state
    chk("R1 count", 64'(sq_count), 0);
    chk("R1 alloc_idx", 64'(alloc_idx), 0);
    chk("R1 alloc_ready", 64'(alloc_ready), 1);
    chk("R1 pending", 64'(wb_pending), 0);
    chk("R1 wb_any", 64'(wb_any), 0);
    chk("R1 req", 64'(mem_req_valid), 0);
    chk("R1 blocked", 64'(store_blocked), 0);

    // Phase A: commit before execute, then drain while accepting.
    alloc(10);
    chk("R2 alloc_idx", 64'(alloc_idx), 1);
    chk("R2 count", 64'(sq_count), 1);
    alloc(11); alloc(12);
    chk("R2 count three", 64'(sq_count), 3);
    commit(100);
    chk("R5 pending all", 64'(wb_pending), 3);
    chk("R6 wb_any", 64'(wb_any), 1);
    chk("R4 no request before execute", 64'(mem_req_valid), 0);
    mem_accept = 1'b1;
    want(10); want(11); want(12);
    exec_st(0, 10); exec_st(1, 11); exec_st(2, 12);
    repeat (5) tick();
    chk("R6 pending drained", 64'(wb_pending), 0);
    chk("R6 wb_any low", 64'(wb_any), 0);
    chk("R8 slots held after accept", 64'(sq_count), 3);
    done_n(3);
    chk("R8 freed by done", 64'(sq_count), 0);
    done_n(1);
    chk("R8 spare done ignored", 64'(sq_count), 0);

    // Phase B: partial commit and refusal with retry.
    mem_accept = 1'b0;
    alloc(20); alloc(21); alloc(22);
    exec_st(3, 20); exec_st(4, 21); exec_st(5, 22);
    want(20); want(21);
    commit(22);
    chk("R5 partial commit pending", 64'(wb_pending), 2);
    chk("R7 request shown", 64'(mem_req_valid), 1);
    chk("R7 request oldest", 64'(mem_req_addr), 64'(a_of(20)));
    tick();
    chk("R9 blocked after refusal", 64'(store_blocked), 1);
    chk("R9 request withdrawn", 64'(mem_req_valid), 0);
    tick();
    chk("R9 still blocked", 64'(store_blocked), 1);
    mem_accept = 1'b1; mem_retry = 1'b1; tick(); mem_retry = 1'b0;
    chk("R9 retry clears block", 64'(store_blocked), 0);
    chk("R9 same store again", 64'(mem_req_addr), 64'(a_of(20)));
    repeat (4) tick();
    chk("R5 younger store kept back", 64'(mem_req_valid), 0);
    chk("R6 pending zero", 64'(wb_pending), 0);
    done_n(2);
    chk("R8 count after two done", 64'(sq_count), 1);

    // Phase C: wrap and squash.
    mem_accept = 1'b0;
    alloc(30); alloc(31); alloc(32); alloc(33);
    chk("R11 alloc_idx wrapped", 64'(alloc_idx), 2);
    chk("R2 count five", 64'(sq_count), 5);
    squash(31);
    chk("R10 count after squash", 64'(sq_count), 3);
    chk("R10 tail pulled back", 64'(alloc_idx), 0);
    mem_accept = 1'b1;
    want(22); want(30); want(31);
    commit(100);
    exec_st(6, 30); exec_st(7, 31);
    repeat (5) tick();
    chk("R10 survivors drained", 64'(wb_pending), 0);
    done_n(3);
    chk("R8 empty again", 64'(sq_count), 0);

    // Squash below a committed store keeps it.
    mem_accept = 1'b0;
    alloc(40); alloc(41);
    commit(41);
    chk("R5 one committed", 64'(wb_pending), 1);
    squash(39);
    chk("R10 committed survives", 64'(sq_count), 1);
    chk("R10 pending kept", 64'(wb_pending), 1);
    chk("R10 tail after squash", 64'(alloc_idx), 1);
    mem_accept = 1'b1;
    want(40);
    exec_st(0, 40);
    repeat (3) tick();
    done_n(1);
    chk("R8 count zero", 64'(sq_count), 0);

    // Phase D: fill to the sentinel limit across the wrap point.
    mem_accept = 1'b0;
    for (int k = 0; k < 7; k++) alloc(50 + k);
    chk("R3 count at limit", 64'(sq_count), 7);
    chk("R3 full", 64'(sq_full), 1);
    chk("R3 alloc_ready low", 64'(alloc_ready), 0);
    alloc(57);
    chk("R3 ignored alloc count", 64'(sq_count), 7);
    chk("R11 ignored alloc idx", 64'(alloc_idx), 0);
    mem_accept = 1'b1;
    for (int k = 0; k < 7; k++) want(50 + k);
    commit(100);
    for (int k = 0; k < 7; k++) exec_st(1 + k, 50 + k);
    repeat (6) tick();
    chk("R6 all drained", 64'(wb_pending), 0);
    chk("R8 full until done", 64'(sq_count), 7);
    done_n(7);
    chk("R3 not full", 64'(sq_full), 0);
    chk("R3 ready again", 64'(alloc_ready), 1);
    chk("R7 every expected write seen", 64'(exp_q.size()), 0);
    finish_run();
  end
endmodule